// File: doc/BRIEF.md
# Dual-Clock Raster Field Store

This block is a byte-wide picture store with a write port and a read port. Each port has its own clock and its own pointer. Pixels are written in scan order (dot by dot, then line by line) and read back in the same order. The writer and the reader need no common clock, so a frame produced at one pixel rate can be shown at another.

Each pointer takes three positioning commands. The first returns it to the top-left pixel. The second sends it back to the first dot of its current line. The third moves it to the first dot of the following line. The line commands let a display path repeat lines (for line doubling or vertical scaling) or skip the rest of a line.

A two-bit mode input chooses the shape of the array (dots per line and lines per field) from three parameterised geometries. The geometry parameters let the store be scaled down for simulation.

Top module: `field_store`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `rd_data_o` is 0 and both pointers sit at dot 0 of line 0.
- R2: On a clock edge with the port's gate high and no command asserted, the pointer advances by one dot. After the last dot of a line it moves to dot 0 of the next line. After the last dot of the last line it moves to dot 0 of line 0. Data written in this order is read back in the same order.
- R3: The home command moves the pointer to dot 0 of line 0 on the next edge of that port's clock. It overrides both line commands.
- R4: The line-restart command moves the pointer to dot 0 of its current line. It overrides the next-line command.
- R5: The next-line command moves the pointer to dot 0 of the next line. From the last line it moves to line 0.
- R6: On an edge with the gate low and no command asserted, the pointer holds, and the read data register holds as well.
- R7: A byte is stored at the write pointer only on a write-clock edge where `wr_gate_i` and `wr_en_i` are both high.
- R8: The byte at the read pointer is captured on a read-clock edge with `rd_gate_i` high and appears on `rd_data_o` after that edge. While `rd_oe_i` is low, `rd_data_o` is 0.
- R9: Mode 0 selects DOTS0×LINES0, mode 1 selects DOTS1×LINES1, mode 2 selects DOTS2×LINES2, and mode 3 behaves as mode 0.
- R10: Pointer commands take effect on any edge of the port's clock, whatever the state of the gate.
- R11: The two ports run from unrelated clocks. Writes and reads at different addresses do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write port clock |
| rd_clk_i | input | 1 | Read port clock |
| rst_ni | input | 1 | Asynchronous reset for both ports, active low |
| mode_i | input | 2 | Geometry select |
| wr_gate_i | input | 1 | Write clock gate (advance enable) |
| wr_en_i | input | 1 | Write enable |
| wr_home_i | input | 1 | Write pointer to top-left |
| wr_line_rst_i | input | 1 | Write pointer to start of current line |
| wr_line_next_i | input | 1 | Write pointer to start of next line |
| wr_data_i | input | 8 | Pixel to store |
| rd_gate_i | input | 1 | Read clock gate (advance and capture enable) |
| rd_oe_i | input | 1 | Output enable |
| rd_home_i | input | 1 | Read pointer to top-left |
| rd_line_rst_i | input | 1 | Read pointer to start of current line |
| rd_line_next_i | input | 1 | Read pointer to start of next line |
| rd_data_o | output | 8 | Read pixel, zero while output enable is low |

## Verification
A pointer in the wrong state is not visible at the ports at once. It shows up as a wrong byte on `rd_data_o` one read-clock cycle after the read pointer reaches the affected address. A wrong write pointer shows up only when that location is later read. The bench therefore writes every location with known data, then mixes commands, gate gaps and enable gaps on both ports against a behavioural reference model, and compares the output on every read clock. A bad line wrap, a wrong command priority or a missing hold then gives a miscompare within one line of reads.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {PTR_STEP, PTR_HOME, PTR_LINE, PTR_NEXT} ptr_op_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fm_geom.sv
module fm_geom #(
  parameter int unsigned DOTS0  = 12,
  parameter int unsigned LINES0 = 4,
  parameter int unsigned DOTS1  = 8,
  parameter int unsigned LINES1 = 6,
  parameter int unsigned DOTS2  = 16,
  parameter int unsigned LINES2 = 3,
  parameter int unsigned DW     = 5,
  parameter int unsigned LW     = 3
) (
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] dots_o,
  output logic [LW-1:0] lines_o
);
  always_comb begin
    unique case (mode_i)
      2'd1: begin dots_o = DW'(DOTS1); lines_o = LW'(LINES1); end
      2'd2: begin dots_o = DW'(DOTS2); lines_o = LW'(LINES2); end
      default: begin dots_o = DW'(DOTS0); lines_o = LW'(LINES0); end
    endcase
  end
endmodule

// File: rtl/fm_ptr.sv
module fm_ptr
  import fm_pkg::*;
#(
  parameter int unsigned DW = 5,
  parameter int unsigned LW = 3,
  localparam int unsigned PW = DW + LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gate_i,
  input  logic          home_i,
  input  logic          line_rst_i,
  input  logic          line_next_i,
  input  logic [DW-1:0] dots_i,
  input  logic [LW-1:0] lines_i,
  output logic [PW-1:0] addr_o
);
  localparam logic [DW-1:0] D_ONE = DW'(1);
  localparam logic [LW-1:0] L_ONE = LW'(1);

  logic [DW-1:0] dot_q;
  logic [LW-1:0] line_q;
  logic [LW-1:0] line_inc;
  logic          last_dot;
  ptr_op_e       op;

  // home beats line restart beats next line
  always_comb begin
    if (home_i)           op = PTR_HOME;
    else if (line_rst_i)  op = PTR_LINE;
    else if (line_next_i) op = PTR_NEXT;
    else                  op = PTR_STEP;
  end

  assign line_inc = (line_q >= lines_i - L_ONE) ? '0 : line_q + L_ONE;
  assign last_dot = (dot_q >= dots_i - D_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      unique case (op)
        PTR_HOME: begin dot_q <= '0; line_q <= '0; end
        PTR_LINE: dot_q <= '0;
        PTR_NEXT: begin dot_q <= '0; line_q <= line_inc; end
        default: if (gate_i) begin
          if (last_dot) begin
            dot_q  <= '0;
            line_q <= line_inc;
          end else begin
            dot_q <= dot_q + D_ONE;
          end
        end
      endcase
    end
  end

  assign addr_o = PW'(line_q) * PW'(dots_i) + PW'(dot_q);

  a_r3_home_top_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    home_i |=> (dot_q == '0) && (line_q == '0));

  a_r4_line_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_rst_i && !home_i |=> (dot_q == '0) && (line_q == $past(line_q)));

  a_r5_next_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_next_i && !home_i && !line_rst_i && (line_q < lines_i - L_ONE)
    |=> (dot_q == '0) && (line_q == $past(line_q) + L_ONE));

  a_r2_dot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i && !home_i && !line_rst_i && !line_next_i && (dot_q < dots_i - D_ONE)
    |=> (dot_q == $past(dot_q) + D_ONE) && $stable(line_q));

  a_r6_hold_no_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i && !home_i && !line_rst_i && !line_next_i
    |=> $stable(dot_q) && $stable(line_q));
endmodule

// File: rtl/fm_array.sv
module fm_array #(
  parameter int unsigned DEPTH = 48,
  parameter int unsigned PW    = 8,
  parameter int unsigned BW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wr_clk_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_addr_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [PW-1:0] rd_addr_i,
  output logic [BW-1:0] rd_data_o
);
  logic [BW-1:0] mem [DEPTH];
  logic          wr_ok, rd_ok;

  assign wr_ok = (wr_addr_i < PW'(DEPTH));
  assign rd_ok = (rd_addr_i < PW'(DEPTH));

  always_ff @(posedge wr_clk_i) begin
    if (wr_i && wr_ok) mem[wr_addr_i[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= rd_ok ? mem[rd_addr_i[AW-1:0]] : '0;
  end

  a_r6_rd_reg_hold: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: rtl/field_store.sv
module field_store
  import fm_pkg::*;
#(
  parameter int unsigned DOTS0  = 12,
  parameter int unsigned LINES0 = 4,
  parameter int unsigned DOTS1  = 8,
  parameter int unsigned LINES1 = 6,
  parameter int unsigned DOTS2  = 16,
  parameter int unsigned LINES2 = 3,
  parameter int unsigned BW     = 8
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          wr_gate_i,
  input  logic          wr_en_i,
  input  logic          wr_home_i,
  input  logic          wr_line_rst_i,
  input  logic          wr_line_next_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic          rd_gate_i,
  input  logic          rd_oe_i,
  input  logic          rd_home_i,
  input  logic          rd_line_rst_i,
  input  logic          rd_line_next_i,
  output logic [BW-1:0] rd_data_o
);
  localparam int unsigned MAX_D = max3(DOTS0, DOTS1, DOTS2);
  localparam int unsigned MAX_L = max3(LINES0, LINES1, LINES2);
  localparam int unsigned DW    = $clog2(MAX_D + 1);
  localparam int unsigned LW    = $clog2(MAX_L + 1);
  localparam int unsigned PW    = DW + LW;
  localparam int unsigned DEPTH = max3(DOTS0 * LINES0, DOTS1 * LINES1, DOTS2 * LINES2);

  logic [DW-1:0] dots;
  logic [LW-1:0] lines;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [BW-1:0] rd_q;

  fm_geom #(
    .DOTS0(DOTS0), .LINES0(LINES0), .DOTS1(DOTS1), .LINES1(LINES1),
    .DOTS2(DOTS2), .LINES2(LINES2), .DW(DW), .LW(LW)
  ) u_geom (
    .mode_i (mode_i),
    .dots_o (dots),
    .lines_o(lines)
  );

  fm_ptr #(.DW(DW), .LW(LW)) u_wr_ptr (
    .clk_i      (wr_clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (wr_gate_i),
    .home_i     (wr_home_i),
    .line_rst_i (wr_line_rst_i),
    .line_next_i(wr_line_next_i),
    .dots_i     (dots),
    .lines_i    (lines),
    .addr_o     (wr_addr)
  );

  fm_ptr #(.DW(DW), .LW(LW)) u_rd_ptr (
    .clk_i      (rd_clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (rd_gate_i),
    .home_i     (rd_home_i),
    .line_rst_i (rd_line_rst_i),
    .line_next_i(rd_line_next_i),
    .dots_i     (dots),
    .lines_i    (lines),
    .addr_o     (rd_addr)
  );

  fm_array #(.DEPTH(DEPTH), .PW(PW), .BW(BW)) u_array (
    .wr_clk_i (wr_clk_i),
    .wr_i     (wr_gate_i & wr_en_i),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data_i),
    .rd_clk_i (rd_clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_gate_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_q)
  );

  assign rd_data_o = rd_oe_i ? rd_q : '0;
endmodule

// File: tb/field_store_test.sv
module field_store_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int D0 = 12, L0 = 4, D1 = 8, L1 = 6, D2 = 16, L2 = 3;

  logic wr_clk = 0, rd_clk = 0, rst_ni = 0;
  logic [1:0] mode = 0;
  logic wr_gate = 0, wr_en = 0, wr_home = 0, wr_line_rst = 0, wr_line_next = 0;
  logic [7:0] wr_data = 0;
  logic rd_gate = 0, rd_oe = 0, rd_home = 0, rd_line_rst = 0, rd_line_next = 0;
  logic [7:0] rd_data;

  int vectors = 0, fails = 0;
  logic [31:0] lfsr = 32'h1badc0de;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  field_store #(.DOTS0(D0), .LINES0(L0), .DOTS1(D1), .LINES1(L1),
                .DOTS2(D2), .LINES2(L2)) uut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni), .mode_i(mode),
    .wr_gate_i(wr_gate), .wr_en_i(wr_en), .wr_home_i(wr_home),
    .wr_line_rst_i(wr_line_rst), .wr_line_next_i(wr_line_next), .wr_data_i(wr_data),
    .rd_gate_i(rd_gate), .rd_oe_i(rd_oe), .rd_home_i(rd_home),
    .rd_line_rst_i(rd_line_rst), .rd_line_next_i(rd_line_next), .rd_data_o(rd_data)
  );

  // ---------------- reference model ----------------
  int mem_m [64];
  int wd = 0, wl = 0, rdt = 0, rln = 0;
  int exp_q = 0;

  function automatic int dots_of(input logic [1:0] m);  // R9
    return (m == 2'd1) ? D1 : (m == 2'd2) ? D2 : D0;
  endfunction
  function automatic int lines_of(input logic [1:0] m);
    return (m == 2'd1) ? L1 : (m == 2'd2) ? L2 : L0;
  endfunction

  task automatic move(inout int d, inout int l, input logic g, h, lr, ln,
                      input int nd, input int nl);
    if (h) begin d = 0; l = 0; end                      // R3
    else if (lr) d = 0;                                  // R4
    else if (ln) begin d = 0; l = (l >= nl - 1) ? 0 : l + 1; end  // R5
    else if (g) begin                                    // R2
      if (d >= nd - 1) begin d = 0; l = (l >= nl - 1) ? 0 : l + 1; end
      else d = d + 1;
    end
  endtask

  always @(posedge wr_clk or negedge rst_ni) begin
    if (!rst_ni) begin wd = 0; wl = 0; end
    else begin
      if (wr_gate && wr_en) mem_m[wl * dots_of(mode) + wd] = int'(wr_data);  // R7
      move(wd, wl, wr_gate, wr_home, wr_line_rst, wr_line_next, dots_of(mode), lines_of(mode));
    end
  end

  always @(posedge rd_clk or negedge rst_ni) begin
    if (!rst_ni) begin rdt = 0; rln = 0; exp_q = 0; end
    else begin
      if (rd_gate) exp_q = mem_m[rln * dots_of(mode) + rdt];  // R8
      move(rdt, rln, rd_gate, rd_home, rd_line_rst, rd_line_next, dots_of(mode), lines_of(mode));
    end
  end

  function automatic logic [31:0] step_lfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(input string req);
    logic [7:0] e;
    e = rd_oe ? 8'(exp_q) : 8'h00;
    vectors++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s: rd_data=%02h expected=%02h at %0t", req, rd_data, e, $time);
    end
  endtask

  task automatic wr_burst(input int n, input bit clean);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      lfsr = step_lfsr(lfsr);
      wr_gate      = clean ? 1'b1 : (lfsr[2:0] != 3'd0);
      wr_en        = clean ? 1'b1 : (lfsr[5:3] != 3'd0);
      wr_home      = !clean && (lfsr[11:6] == 6'd0);
      wr_line_rst  = !clean && (lfsr[11:6] == 6'd1 || lfsr[11:6] == 6'd4);
      wr_line_next = !clean && (lfsr[11:6] == 6'd2 || lfsr[11:6] == 6'd4);
      wr_data      = lfsr[23:16];
    end
    @(negedge wr_clk);
    {wr_gate, wr_en, wr_home, wr_line_rst, wr_line_next} = '0;
  endtask

  task automatic rd_burst(input int n, input bit clean, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      check(req);
      lfsr = step_lfsr(lfsr);
      rd_gate      = clean ? 1'b1 : (lfsr[2:0] != 3'd0);
      rd_oe        = clean ? 1'b1 : (lfsr[4:3] != 2'd0);
      rd_home      = !clean && (lfsr[10:5] == 6'd0 || lfsr[10:5] == 6'd5);
      rd_line_rst  = !clean && (lfsr[10:5] == 6'd1 || lfsr[10:5] == 6'd4 || lfsr[10:5] == 6'd5);
      rd_line_next = !clean && (lfsr[10:5] == 6'd2 || lfsr[10:5] == 6'd4 || lfsr[10:5] == 6'd5);
    end
    @(negedge rd_clk);
    check(req);
    {rd_gate, rd_home, rd_line_rst, rd_line_next} = '0;
  endtask

  task automatic home_both();
    @(negedge wr_clk); wr_home = 1'b1;
    @(negedge wr_clk); wr_home = 1'b0;
    @(negedge rd_clk); rd_home = 1'b1; check("R3");
    @(negedge rd_clk); rd_home = 1'b0; check("R3");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rd_oe = 1'b1;
    #(CLK_PERIOD * 3);
    @(negedge rd_clk); check("R1");
    rst_ni = 1'b1;
    @(negedge rd_clk); check("R1");
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      home_both();
      wr_burst(48, 1'b1);                       // R2 R9 fill in raster order
      rd_burst(60, 1'b1, "R2_R9");              // includes field wrap
      wr_burst(400, 1'b0);                      // R3 R4 R5 R6 R7 R10
      rd_burst(400, 1'b0, "R3_R4_R5_R6_R8_R10");
      // concurrent ports on unrelated clocks: write gate held low, reads continue
      fork
        begin
          @(negedge wr_clk); wr_en = 1'b1; wr_gate = 1'b0; wr_data = 8'hA5;
          repeat (20) @(negedge wr_clk);
          wr_en = 1'b0;
        end
        rd_burst(20, 1'b1, "R11_R7");
      join
      rd_oe = 1'b0;
      rd_burst(10, 1'b1, "R8");
      rd_oe = 1'b1;
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule